// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array with Row Buffer

This block is a synthesizable behavioural model of a small dynamic memory and the controller in front of it. Storage is a grid of supercells, by default 4 rows by 4 columns of 8 bits each. The array is never read or written one word at a time. Every access first opens a row, which copies that whole row into an internal row buffer. It then selects one column from that buffer. The row index and the column index take turns on one narrow address bus, and each is marked by its own strobe.

A host issues a flat request over a valid/ready handshake. Each request carries an address, a write flag and write data. The controller splits the address into a row phase and a column phase. It returns the addressed supercell on a one-cycle response pulse. A write changes the buffered copy of the cell during the column phase. The buffer is then written back into the array row before any other row is opened. A timer raises a refresh request at a programmable interval. When the controller is idle, refresh wins over the host: it opens the next row in round-robin order and writes that row back unchanged.

Top module: `mux_dram`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, dram_ras and dram_cas are 0, and every supercell reads back as zero.
- R2: The flat address req_addr is split so that its upper log2(ROWS) bits give the row and its lower log2(COLS) bits give the column. For example, address 4'b1001 selects row 2, column 1.
- R3: A request is taken at a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the controller returns to idle, so one access takes four cycles.
- R4: In the cycle after acceptance, dram_ras is 1 and dram_addr carries the row. In the cycle after that, dram_cas is 1 and dram_addr carries the column. The two strobes are never high together.
- R5: rsp_valid is 1 for exactly one cycle, the cycle after the column strobe. In that cycle rsp_rdata carries the addressed supercell.
- R6: A write stores req_wdata into the addressed supercell and leaves every other supercell unchanged. Its response carries the value the cell held before the write.
- R7: Opening a row copies the whole row into the row buffer. A write made through the buffer reaches the array before any later access or refresh opens a row, so an access that follows at once, to the same row or another row, sees the written value.
- R8: A refresh request is raised once every REFRESH_CYCLES cycles. Refresh is served as a row strobe with no column strobe after it, and it visits rows 0, 1, …, ROWS-1 in cyclic order.
- R9: When a refresh is pending and the controller is idle, req_ready is 0 even while req_valid is 1. The refresh runs for two cycles, and the waiting host request is accepted in the cycle after that.
- R10: Refresh rewrites a row with its own contents, so stored data is unchanged by any number of refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Flat address: row in upper bits, column in lower bits |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Read data (for a write, the cell's previous contents) |
| dram_addr | output | 2 | Multiplexed row/column address bus |
| dram_ras | output | 1 | Row strobe |
| dram_cas | output | 1 | Column strobe |

## Verification
The host request and a refresh request can both be present in the same idle cycle. The bench provokes this by first timing a refresh row strobe while the host is quiet. It counts exactly one refresh interval minus one cycle and raises req_valid in the cycle when the next refresh becomes pending. It then checks that req_ready stays low and that a refresh row strobe for the next row in sequence appears with no column strobe after it. It also checks that the host request is taken two cycles later, and that its row and column phases and its returned data match the model kept in the bench.

// File: rtl/dram_pkg.sv
package dram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RAS  = 3'd1,
      ST_CAS  = 3'd2,
      ST_DONE = 3'd3,
      ST_RRAS = 3'd4,
      ST_RWB  = 3'd5
   } ctrl_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int DW   = 8,
   localparam int RA_W  = $clog2(ROWS),
   localparam int ROW_W = COLS * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RA_W-1:0]  row_sel,
   input  logic [ROW_W-1:0] wr_row_data,
   output logic [ROW_W-1:0] rd_row_data
);

   logic [ROW_W-1:0] row_w [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [ROW_W-1:0] cells_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells_q <= '0;
         end else if (wr_en && (row_sel == RA_W'(r))) begin
            cells_q <= wr_row_data;
         end
      end
      assign row_w[r] = cells_q;
   end

   assign rd_row_data = row_w[row_sel];

   // R7 / R10: a row write-back lands in the addressed row
   p_row_writeback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (row_w[$past(row_sel)] == $past(wr_row_data)));

endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
   parameter int COLS = 4,
   parameter int DW   = 8,
   localparam int CA_W  = $clog2(COLS),
   localparam int ROW_W = COLS * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] load_data,
   input  logic             col_wr,
   input  logic [CA_W-1:0]  col_sel,
   input  logic [DW-1:0]    col_wdata,
   output logic [ROW_W-1:0] row_q,
   output logic [DW-1:0]    col_rdata
);

   logic [DW-1:0] col_w [COLS];

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else if (load) begin
            cell_q <= load_data[c*DW +: DW];
         end else if (col_wr && (col_sel == CA_W'(c))) begin
            cell_q <= col_wdata;
         end
      end
      assign col_w[c]         = cell_q;
      assign row_q[c*DW +: DW] = cell_q;
   end

   assign col_rdata = col_w[col_sel];

   // R7: a row strobe copies the whole row into the buffer
   p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (row_q == $past(load_data)));

   // R6: a column write changes only the selected column
   p_col_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (col_wr && !load) |=> (col_w[$past(col_sel)] == $past(col_wdata)));

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int ROWS     = 4,
   parameter int INTERVAL = 1600000,
   localparam int RA_W = $clog2(ROWS),
   localparam int CW   = $clog2(INTERVAL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            grant,
   input  logic            done,
   output logic            pend,
   output logic [RA_W-1:0] rrow
);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == CW'(INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pend  <= 1'b0;
         rrow  <= '0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         if (wrap) begin
            pend <= 1'b1;
         end else if (grant) begin
            pend <= 1'b0;
         end
         if (done) begin
            rrow <= rrow + 1'b1;
         end
      end
   end

   // R8: a raised refresh request waits until it is granted
   p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !grant) |=> pend);

   // R8: the row pointer steps by one per completed refresh
   p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (rrow == $past(rrow) + 1'b1));

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_pkg::*;
#(
   parameter int RA_W = 2,
   parameter int CA_W = 2,
   parameter int DW   = 8,
   localparam int AW   = RA_W + CA_W,
   localparam int AB_W = max2(RA_W, CA_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   output logic            rsp_valid,
   output logic [DW-1:0]   rsp_rdata,
   input  logic            rfsh_pend,
   input  logic [RA_W-1:0] rfsh_row,
   output logic            rfsh_grant,
   output logic            rfsh_done,
   output logic            ras,
   output logic            cas,
   output logic [AB_W-1:0] mem_addr,
   output logic            buf_load,
   output logic            buf_col_wr,
   output logic [CA_W-1:0] buf_col_sel,
   output logic [DW-1:0]   buf_wdata,
   input  logic [DW-1:0]   buf_rdata,
   output logic            arr_wr,
   output logic [RA_W-1:0] arr_row
);

   ctrl_state_t     st_q, st_d;
   logic [RA_W-1:0] row_q;
   logic [CA_W-1:0] col_q;
   logic            wr_q;
   logic [DW-1:0]   wd_q;
   logic [DW-1:0]   rd_q;
   logic            accept;

   assign req_ready  = (st_q == ST_IDLE) && !rfsh_pend;
   assign accept     = req_valid && req_ready;
   assign rfsh_grant = (st_q == ST_IDLE) && rfsh_pend;
   assign rfsh_done  = (st_q == ST_RWB);

   assign ras = (st_q == ST_RAS) || (st_q == ST_RRAS);
   assign cas = (st_q == ST_CAS);

   always_comb begin
      unique case (st_q)
         ST_RAS:  mem_addr = AB_W'(row_q);
         ST_RRAS: mem_addr = AB_W'(rfsh_row);
         ST_CAS:  mem_addr = AB_W'(col_q);
         default: mem_addr = '0;
      endcase
   end

   assign arr_row     = ((st_q == ST_RRAS) || (st_q == ST_RWB)) ? rfsh_row : row_q;
   assign buf_load    = ras;
   assign buf_col_wr  = (st_q == ST_CAS) && wr_q;
   assign buf_col_sel = col_q;
   assign buf_wdata   = wd_q;
   assign arr_wr      = ((st_q == ST_DONE) && wr_q) || (st_q == ST_RWB);
   assign rsp_valid   = (st_q == ST_DONE);
   assign rsp_rdata   = rd_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (rfsh_grant) st_d = ST_RRAS;
            else if (accept) st_d = ST_RAS;
         end
         ST_RAS:  st_d = ST_CAS;
         ST_CAS:  st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         ST_RRAS: st_d = ST_RWB;
         ST_RWB:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         row_q <= '0;
         col_q <= '0;
         wr_q  <= 1'b0;
         wd_q  <= '0;
         rd_q  <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            row_q <= req_addr[AW-1 -: RA_W];
            col_q <= req_addr[CA_W-1:0];
            wr_q  <= req_write;
            wd_q  <= req_wdata;
         end
         if (st_q == ST_CAS) begin
            rd_q <= buf_rdata;
         end
      end
   end

   // R3: after acceptance the controller is busy
   p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R4: row phase follows acceptance with the row on the bus
   p_row_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (ras && (mem_addr == AB_W'($past(req_addr[AW-1 -: RA_W])))));

   // R4: column strobe only after a row strobe, never together
   p_cas_after_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cas |-> $past(ras));
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ras && cas));

   // R5: response follows the column strobe and lasts one cycle
   p_rsp_after_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cas));
   p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R9: a granted refresh opens its row and keeps the host waiting
   p_refresh_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_grant |=> (ras && !req_ready && (mem_addr == AB_W'($past(rfsh_row)))));
   p_grant_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_grant |-> !accept);

   // R8: a refresh row strobe is not followed by a column strobe
   p_refresh_no_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_grant |=> ##1 !cas);

endmodule

// File: rtl/mux_dram.sv
module mux_dram
   import dram_pkg::*;
#(
   parameter int ROWS           = 4,
   parameter int COLS           = 4,
   parameter int DATA_W         = 8,
   parameter int REFRESH_CYCLES = 1600000,
   localparam int RA_W  = $clog2(ROWS),
   localparam int CA_W  = $clog2(COLS),
   localparam int AW    = RA_W + CA_W,
   localparam int AB_W  = max2(RA_W, CA_W),
   localparam int ROW_W = COLS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [AB_W-1:0]   dram_addr,
   output logic              dram_ras,
   output logic              dram_cas
);

   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("COLS must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end
   if (REFRESH_CYCLES < 8) begin : g_bad_ref
      $error("REFRESH_CYCLES must be at least 8");
   end

   logic              rfsh_pend, rfsh_grant, rfsh_done;
   logic [RA_W-1:0]   rfsh_row;
   logic              buf_load, buf_col_wr;
   logic [CA_W-1:0]   buf_col_sel;
   logic [DATA_W-1:0] buf_wdata, buf_rdata;
   logic [ROW_W-1:0]  buf_row, arr_rd;
   logic              arr_wr;
   logic [RA_W-1:0]   arr_row;

   dram_seq_ctrl #(.RA_W(RA_W), .CA_W(CA_W), .DW(DATA_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .rfsh_pend   (rfsh_pend),
      .rfsh_row    (rfsh_row),
      .rfsh_grant  (rfsh_grant),
      .rfsh_done   (rfsh_done),
      .ras         (dram_ras),
      .cas         (dram_cas),
      .mem_addr    (dram_addr),
      .buf_load    (buf_load),
      .buf_col_wr  (buf_col_wr),
      .buf_col_sel (buf_col_sel),
      .buf_wdata   (buf_wdata),
      .buf_rdata   (buf_rdata),
      .arr_wr      (arr_wr),
      .arr_row     (arr_row)
   );

   dram_refresh_timer #(.ROWS(ROWS), .INTERVAL(REFRESH_CYCLES)) u_rfsh (
      .clk   (clk),
      .rst_n (rst_n),
      .grant (rfsh_grant),
      .done  (rfsh_done),
      .pend  (rfsh_pend),
      .rrow  (rfsh_row)
   );

   dram_row_buffer #(.COLS(COLS), .DW(DATA_W)) u_rbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (buf_load),
      .load_data (arr_rd),
      .col_wr    (buf_col_wr),
      .col_sel   (buf_col_sel),
      .col_wdata (buf_wdata),
      .row_q     (buf_row),
      .col_rdata (buf_rdata)
   );

   dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .DW(DATA_W)) u_arr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (arr_wr),
      .row_sel     (arr_row),
      .wr_row_data (buf_row),
      .rd_row_data (arr_rd)
   );

   // R10: a refresh write-back rewrites exactly what the row strobe read
   p_refresh_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_done |-> (buf_row == arr_rd));

endmodule

// File: tb/test_mux_dram.sv
module test_mux_dram;

   localparam int N = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       rsp_valid;
   logic [7:0] rsp_rdata;
   logic [1:0] dram_addr;
   logic       dram_ras;
   logic       dram_cas;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 0;
   int mdl [16];
   int last_rrow = 0;

   always #(10ns) clk = ~clk;

   mux_dram #(.ROWS(4), .COLS(4), .DATA_W(8), .REFRESH_CYCLES(N)) i_mux_dram (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .dram_addr (dram_addr),
      .dram_ras  (dram_ras),
      .dram_cas  (dram_cas)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One host access with full phase checking against the model
   task automatic access(input bit wr, input int a, input int d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = 4'(a);
      req_wdata = 8'(d);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R4 row strobe", int'(dram_ras), 1);
      chk("R2 row on bus", int'(dram_addr), a >> 2);
      chk("R3 busy after accept", int'(req_ready), 0);
      @(negedge clk);
      chk("R4 column strobe", int'(dram_cas), 1);
      chk("R4 strobes exclusive", int'(dram_ras), 0);
      chk("R2 column on bus", int'(dram_addr), a & 3);
      @(negedge clk);
      chk("R5 response valid", int'(rsp_valid), 1);
      if (wr) chk("R6 write returns old value", int'(rsp_rdata), mdl[a]);
      else    chk("R5 read data", int'(rsp_rdata), mdl[a]);
      if (wr) mdl[a] = d & 8'hff;
      @(negedge clk);
      chk("R5 response one cycle", int'(rsp_valid), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 ready after reset", int'(req_ready), 1);
      chk("R1 no response after reset", int'(rsp_valid), 0);
      chk("R1 no row strobe after reset", int'(dram_ras), 0);
      chk("R1 no column strobe after reset", int'(dram_cas), 0);
      for (int a = 0; a < 16; a++) access(1'b0, a, 0);
   endtask

   task automatic t_write_fill();
      for (int a = 0; a < 16; a++) access(1'b1, a, (a * 37 + 5) & 8'hff);
      for (int a = 15; a >= 0; a--) access(1'b0, a, 0);
      // R6: rewrite one cell, neighbours of its row stay intact
      access(1'b1, 9, 8'ha5);
      access(1'b1, 9, 8'h3c);
      for (int c = 0; c < 4; c++) access(1'b0, 8 + c, 0);
   endtask

   task automatic t_row_buffer();
      // R7: write then access same row / other row at once
      access(1'b1, 6, 8'h11);
      access(1'b0, 7, 0);
      access(1'b0, 6, 0);
      access(1'b1, 1, 8'h22);
      access(1'b1, 13, 8'h33);
      access(1'b0, 1, 0);
      access(1'b0, 13, 0);
   endtask

   task automatic t_mixed();
      int unsigned s = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
         s = s * 32'd1103515245 + 32'd12345;
         access(s[20], int'(s[27:24]), int'(s[15:8]));
      end
   endtask

   task automatic t_refresh_interval();
      int last_t = -1;
      int last_row = -1;
      int pulses = 0;
      bit prev_ras = 1'b0;
      for (int cyc = 0; cyc < 4 * N + 5; cyc++) begin
         @(negedge clk);
         if (prev_ras) chk("R8 refresh without column strobe", int'(dram_cas), 0);
         if (dram_ras) begin
            chk("R9 host held during refresh", int'(req_ready), 0);
            if (last_t >= 0) begin
               chk("R8 refresh interval", cyc - last_t, N);
               chk("R8 refresh row order", int'(dram_addr), (last_row + 1) % 4);
            end
            last_t = cyc;
            last_row = int'(dram_addr);
            pulses++;
         end
         prev_ras = dram_ras;
      end
      chk("R8 refresh count", pulses, 4);
      last_rrow = last_row;
   endtask

   task automatic t_refresh_keeps();
      for (int a = 0; a < 16; a++) access(1'b0, a, 0);  // R10
   endtask

   task automatic t_priority();
      int r = -1;
      for (int i = 0; i < 2 * N && r < 0; i++) begin
         @(negedge clk);
         if (dram_ras) r = int'(dram_addr);
      end
      chk("R8 refresh seen before contention", int'(r >= 0), 1);
      repeat (N - 1) @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = 4'he;
      chk("R9 ready low when refresh pending", int'(req_ready), 0);
      @(negedge clk);
      chk("R9 refresh wins row strobe", int'(dram_ras), 1);
      chk("R9 refresh row", int'(dram_addr), (r + 1) % 4);
      chk("R9 host still held", int'(req_ready), 0);
      @(negedge clk);
      chk("R9 refresh write-back cycle no strobes", int'(dram_ras | dram_cas), 0);
      chk("R9 host held in write-back", int'(req_ready), 0);
      @(negedge clk);
      chk("R9 host accepted after refresh", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 host row strobe", int'(dram_ras), 1);
      chk("R9 host row", int'(dram_addr), 3);
      @(negedge clk);
      chk("R9 host column", int'(dram_addr), 2);
      chk("R9 host column strobe", int'(dram_cas), 1);
      @(negedge clk);
      chk("R9 host response", int'(rsp_valid), 1);
      chk("R10 host data after refresh", int'(rsp_rdata), mdl[14]);
   endtask

   initial begin
      for (int a = 0; a < 16; a++) mdl[a] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_fill();
      t_row_buffer();
      t_mixed();
      t_refresh_interval();
      t_refresh_keeps();
      t_priority();
      repeat (4) @(negedge clk);
      if (!done_flag) begin
         done_flag = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule